// File: doc/BRIEF.md
# On-State Open-Load Fault Filter

This block watches the two outputs of a half-bridge for a missing or open load while the bridge is driving. Each high-side recirculation switching cycle arrives as a one-cycle `strobe`. A `spike` flag comes with each strobe. The flag is high when the output was seen rising above supply during the dead time, which is what an inductive load produces. A missing spike means the inductance is gone or the load resistance has grown. The drive direction `dir` selects which output is recirculating on a given strobe, and so which of the two status bits the strobe affects.

A run counter tracks consecutive valid strobes of the same polarity: either all with a spike, or all without one. The run length needed is 16, or 1024 when `long_sel` is high. A full run without a spike sets the status bit of the checked output.

There are two ways to recover:
- In retry mode, a full run with spikes clears the bit on its own.
- In latch mode, the bit stays set until a `clr_flt` pulse.

While any status bit is set, the active-low `fault_n` output is low. The bridge drive and the current sense are not touched by this block.

Top module: `ola_filter`

## Requirements
- R1: After reset both bits of `stat` are 0 and `fault_n` is 1.
- R2: With `long_sel`=0, the 16th consecutive valid strobe with `spike`=0 sets `stat[dir]`, visible one clock after that strobe. After 15 such strobes the bit is still 0.
- R3: With `long_sel`=1 the run length is 1024. After 1023 valid no-spike strobes the bit is 0, and after the 1024th it is 1.
- R4: A strobe counts as valid only when `en`, `active` and `hs_recirc` are all 1. A strobe with `hs_recirc`=0 (low-side recirculation) changes neither the count nor `stat`.
- R5: In retry mode (`latch_mode`=0), a set bit clears one clock after the 16th (or 1024th) consecutive valid strobe with `spike`=1 for that output.
- R6: A valid strobe of the opposite polarity restarts the run. The opposing strobe counts as the first of a new run, and the count stops growing at the threshold.
- R7: In latch mode (`latch_mode`=1), spike runs do not clear a set bit. A `clr_flt` pulse clears both bits on the next clock, whether or not the load is still open.
- R8: In latch mode, `clr_flt` also restarts the run. An open load that persists after the clear sets the bit again after a full new run of no-spike strobes.
- R9: In retry mode, `clr_flt` has no effect on `stat` or on the run count.
- R10: Any change of `dir` between clocks restarts the run, in both modes. `dir`=0 selects `stat[0]` and `dir`=1 selects `stat[1]`.
- R11: `fault_n` is 0 exactly when at least one bit of `stat` is 1.
- R12: While `en`=0 or `active`=0, the run restarts and retry-mode bits clear on the next clock. Latch-mode bits keep their value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Enables the open-load check |
| active | input | 1 | Bridge is in its driving state |
| hs_recirc | input | 1 | 1 = high-side recirculation, 0 = low-side |
| long_sel | input | 1 | 0 = 16-cycle run, 1 = 1024-cycle run |
| latch_mode | input | 1 | 0 = retry recovery, 1 = latched until clear |
| dir | input | 1 | Drive direction; selects the output being checked |
| clr_flt | input | 1 | Clear-fault pulse (latch mode only) |
| strobe | input | 1 | One recirculation switching cycle is complete |
| spike | input | 1 | Spike above supply seen during dead time, qualified by `strobe` |
| stat | output | 2 | Open-load status, one bit per output |
| fault_n | output | 1 | Active-low fault indication |

## Verification
The bench looks for off-by-one errors in the filter. It drives runs of 15 and 16 no-spike strobes, and 1023 and 1024 in long mode. A counter compared one step too early or too late would set the fault a strobe early or late. It also places a single spike inside a miss run: a design that only paused the count would still declare a fault. It flips `dir` in the middle of a run: a counter not restarted on the flip would let misses on one output complete a run for the other. Clears are issued in both modes while the load stays open. A latch design that kept its saturated count would set the bit again at once, and a retry design that honoured the clear would drop a valid fault.

// File: rtl/ola_pkg.sv
package ola_pkg;

  // Number of monitored outputs of the half-bridge.
  localparam int unsigned NUM_OUT = 2;

  // Recovery behaviour of a set status bit.
  typedef enum logic {
    REC_RETRY = 1'b0,
    REC_LATCH = 1'b1
  } rec_mode_e;

  // Polarity of the current run of strobes.
  typedef enum logic {
    RUN_MISS  = 1'b0,
    RUN_SPIKE = 1'b1
  } run_pol_e;

endpackage

// File: rtl/ola_run_counter.sv
module ola_run_counter
  import ola_pkg::*;
#(
  parameter int unsigned CW = 11
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic          tick,
  input  logic          spike,
  input  logic [CW-1:0] thresh,
  output logic          miss_done,
  output logic          good_done
);

  logic [CW-1:0] cnt_q, cnt_d, base;
  run_pol_e      pol_q, pol_d;
  run_pol_e      pol_in;
  logic          upd_en;

  assign pol_in = spike ? RUN_SPIKE : RUN_MISS;
  assign upd_en = restart | tick;

  // Next-state: restart drops the run, a tick extends or restarts it.
  always_comb begin
    base  = restart ? '0 : cnt_q;
    cnt_d = base;
    pol_d = pol_q;
    if (tick) begin
      if ((base != '0) && (pol_q == pol_in)) begin
        cnt_d = (base >= thresh) ? base : CW'(base + 1'b1);
      end else begin
        cnt_d = CW'(1);
        pol_d = pol_in;
      end
    end
  end

  assign miss_done = tick && (pol_in == RUN_MISS)  && (cnt_d >= thresh);
  assign good_done = tick && (pol_in == RUN_SPIKE) && (cnt_d >= thresh);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      pol_q <= RUN_MISS;
    end else if (upd_en) begin
      cnt_q <= cnt_d;
      pol_q <= pol_d;
    end
  end

endmodule

// File: rtl/ola_status_bits.sv
module ola_status_bits
  import ola_pkg::*;
#(
  parameter int unsigned NOUT = 2,
  localparam int unsigned SW  = (NOUT > 1) ? $clog2(NOUT) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  rec_mode_e       mode,
  input  logic            run,
  input  logic            clr_flt,
  input  logic [SW-1:0]   sel,
  input  logic            miss_done,
  input  logic            good_done,
  output logic [NOUT-1:0] stat
);

  for (genvar g = 0; g < NOUT; g++) begin : g_bit
    logic bit_q, bit_d, hit;

    assign hit = (sel == SW'(g));

    always_comb begin
      bit_d = bit_q;
      if ((mode == REC_LATCH) && clr_flt) begin
        bit_d = 1'b0;
      end else if ((mode == REC_RETRY) && !run) begin
        bit_d = 1'b0;
      end else if (hit && miss_done) begin
        bit_d = 1'b1;
      end else if (hit && good_done && (mode == REC_RETRY)) begin
        bit_d = 1'b0;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        bit_q <= 1'b0;
      end else begin
        bit_q <= bit_d;
      end
    end

    assign stat[g] = bit_q;
  end

endmodule

// File: rtl/ola_filter.sv
module ola_filter
  import ola_pkg::*;
#(
  parameter int unsigned SHORT_N = 16,
  parameter int unsigned LONG_N  = 1024,
  localparam int unsigned CW     = $clog2(LONG_N + 1)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               en,
  input  logic               active,
  input  logic               hs_recirc,
  input  logic               long_sel,
  input  logic               latch_mode,
  input  logic               dir,
  input  logic               clr_flt,
  input  logic               strobe,
  input  logic               spike,
  output logic [NUM_OUT-1:0] stat,
  output logic               fault_n
);

  logic          run, tick, dir_q, dir_chg, restart;
  logic          miss_done, good_done;
  logic [CW-1:0] thresh;
  rec_mode_e     mode;

  assign mode    = latch_mode ? REC_LATCH : REC_RETRY;
  assign run     = en & active;
  assign tick    = run & strobe & hs_recirc;
  assign dir_chg = dir ^ dir_q;
  assign restart = ~run | dir_chg | ((mode == REC_LATCH) & clr_flt);
  assign thresh  = long_sel ? CW'(LONG_N) : CW'(SHORT_N);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= 1'b0;
    end else begin
      dir_q <= dir;
    end
  end

  ola_run_counter #(.CW(CW)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (restart),
    .tick      (tick),
    .spike     (spike),
    .thresh    (thresh),
    .miss_done (miss_done),
    .good_done (good_done)
  );

  ola_status_bits #(.NOUT(NUM_OUT)) u_stat (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .run       (run),
    .clr_flt   (clr_flt),
    .sel       (dir),
    .miss_done (miss_done),
    .good_done (good_done),
    .stat      (stat)
  );

  assign fault_n = ~(|stat);

endmodule

// File: rtl/ola_filter_chk.sv
module ola_filter_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       en,
  input logic       active,
  input logic       hs_recirc,
  input logic       latch_mode,
  input logic       dir,
  input logic       clr_flt,
  input logic       strobe,
  input logic       spike,
  input logic [1:0] stat
);

  p_latch_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_mode && clr_flt) |=> (stat == 2'b00));

  p_retry_idle_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!latch_mode && !(en && active)) |=> (stat == 2'b00));

  p_no_tick_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (en && active && !clr_flt && !(strobe && hs_recirc)) |=> $stable(stat));

  p_retry_clr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!latch_mode && clr_flt && en && active && !(strobe && hs_recirc)) |=> $stable(stat));

  p_set_out0_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat[0]) |-> $past(strobe && hs_recirc && !spike && !dir && en && active));

  p_set_out1_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat[1]) |-> $past(strobe && hs_recirc && !spike && dir && en && active));

endmodule

bind ola_filter ola_filter_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .en         (en),
  .active     (active),
  .hs_recirc  (hs_recirc),
  .latch_mode (latch_mode),
  .dir        (dir),
  .clr_flt    (clr_flt),
  .strobe     (strobe),
  .spike      (spike),
  .stat       (stat)
);

// File: tb/tb_ola_filter.sv
`timescale 1ns/1ps
module tb_ola_filter;

  logic clk, rst_n;
  logic en, active, hs_recirc, long_sel, latch_mode, dir, clr_flt, strobe, spike;
  logic [1:0] stat;
  logic fault_n;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  // Reference state, derived from the requirements
  int   m_cnt;
  bit   m_pol;
  bit   m_dirq;
  bit [1:0] m_stat;

  ola_filter dut (
    .clk(clk), .rst_n(rst_n), .en(en), .active(active), .hs_recirc(hs_recirc),
    .long_sel(long_sel), .latch_mode(latch_mode), .dir(dir), .clr_flt(clr_flt),
    .strobe(strobe), .spike(spike), .stat(stat), .fault_n(fault_n)
  );

  initial clk = 0;
  always #4 clk = ~clk;

  function automatic int thr(input bit ls);
    return ls ? 1024 : 16;
  endfunction

  task automatic model_step();
    bit run, tick, restart;
    int base, ncnt, n;
    bit npol, miss, good;
    run     = en && active;
    tick    = run && strobe && hs_recirc;
    restart = !run || (dir != m_dirq) || (latch_mode && clr_flt);
    n       = thr(long_sel);
    base    = restart ? 0 : m_cnt;
    ncnt    = base;
    npol    = m_pol;
    if (tick) begin
      if (base != 0 && m_pol == spike) ncnt = (base >= n) ? base : base + 1;
      else begin ncnt = 1; npol = spike; end
    end
    miss = tick && !spike && ncnt >= n;
    good = tick && spike && ncnt >= n;
    for (int i = 0; i < 2; i++) begin
      if (latch_mode && clr_flt) m_stat[i] = 0;
      else if (!latch_mode && !run) m_stat[i] = 0;
      else if (miss && dir == i[0]) m_stat[i] = 1;
      else if (good && !latch_mode && dir == i[0]) m_stat[i] = 0;
    end
    m_cnt  = ncnt;
    m_pol  = npol;
    m_dirq = dir;
  endtask

  task automatic check_model(input string tag);
    checks++;
    if (stat !== m_stat || fault_n !== ~(|m_stat)) begin
      errors++;
      $display("FAIL %s: stat=%b fault_n=%b expected stat=%b fault_n=%b",
               tag, stat, fault_n, m_stat, ~(|m_stat));
    end
  endtask

  task automatic expect_stat(input logic [1:0] exp, input string tag);
    checks++;
    if (stat !== exp || fault_n !== ~(|exp)) begin
      errors++;
      $display("FAIL %s: stat=%b fault_n=%b expected stat=%b fault_n=%b",
               tag, stat, fault_n, exp, ~(|exp));
    end
  endtask

  // One clock: inputs already set at negedge; advance model and compare
  task automatic step(input string tag);
    model_step();
    @(negedge clk);
    check_model(tag);
    clr_flt = 0;
    strobe  = 0;
  endtask

  task automatic strobes(input int n, input bit spk, input string tag);
    for (int i = 0; i < n; i++) begin
      strobe = 1; spike = spk;
      step(tag);
    end
  endtask

  task automatic idle(input int n, input string tag);
    for (int i = 0; i < n; i++) step(tag);
  endtask

  task automatic pulse_clr(input string tag);
    clr_flt = 1;
    step(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not finish, expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd4242));
    rst_n = 0; en = 0; active = 0; hs_recirc = 0; long_sel = 0; latch_mode = 0;
    dir = 0; clr_flt = 0; strobe = 0; spike = 0;
    m_cnt = 0; m_pol = 0; m_dirq = 0; m_stat = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    expect_stat(2'b00, "R1 reset");

    // R2 / R11: short filter, retry mode, output 0
    en = 1; active = 1; hs_recirc = 1;
    strobes(15, 0, "R2 run of 15");
    expect_stat(2'b00, "R2 15 misses");
    strobes(1, 0, "R2 16th");
    expect_stat(2'b01, "R2/R11 16th miss sets");
    // R5: retry recovery
    strobes(15, 1, "R5 spikes");
    expect_stat(2'b01, "R5 15 spikes");
    strobes(1, 1, "R5 16th spike");
    expect_stat(2'b00, "R5 cleared");

    // R6: opposite polarity restarts the run
    strobes(15, 0, "R6 misses");
    strobes(1, 1, "R6 single spike");
    strobes(15, 0, "R6 misses");
    expect_stat(2'b00, "R6 broken run");
    strobes(1, 0, "R6 completing");
    expect_stat(2'b01, "R6 new run completes");
    strobes(20, 0, "R6 saturate");
    expect_stat(2'b01, "R6 saturated");

    // R9: clear ignored in retry mode
    pulse_clr("R9 clr");
    expect_stat(2'b01, "R9 clr no effect");
    strobes(16, 1, "R9 recover");
    expect_stat(2'b00, "R9 count kept");

    // R4: low-side recirculation ignored
    hs_recirc = 0;
    strobes(40, 0, "R4 low-side");
    expect_stat(2'b00, "R4 ignored");
    hs_recirc = 1;
    strobes(10, 0, "R4 misses");
    hs_recirc = 0;
    strobes(5, 1, "R4 low-side spikes");
    hs_recirc = 1;
    strobes(6, 0, "R4 resumed");
    expect_stat(2'b01, "R4 run not broken");

    // R12: disable clears retry bit
    en = 0;
    idle(1, "R12 disable");
    expect_stat(2'b00, "R12 retry cleared");
    en = 1;
    strobes(10, 0, "R12 misses");
    active = 0;
    idle(1, "R12 inactive");
    active = 1;
    strobes(10, 0, "R12 after");
    expect_stat(2'b00, "R12 counter reset");
    strobes(16, 1, "R12 settle");

    // R10: direction change restarts and selects output 1
    strobes(10, 0, "R10 dir0");
    dir = 1;
    strobes(10, 0, "R10 dir1");
    expect_stat(2'b00, "R10 restart on flip");
    strobes(6, 0, "R10 dir1");
    expect_stat(2'b10, "R10 output 1");
    dir = 0;
    strobes(16, 0, "R10 dir0");
    expect_stat(2'b11, "R10/R11 both");
    en = 0; idle(1, "R10 clear"); en = 1;

    // R7 / R8: latch mode
    latch_mode = 1;
    strobes(16, 0, "R7 set");
    expect_stat(2'b01, "R7 latched");
    strobes(40, 1, "R7 spikes");
    expect_stat(2'b01, "R7 held");
    en = 0;
    idle(2, "R12 latch hold");
    expect_stat(2'b01, "R12 latched held");
    en = 1;
    pulse_clr("R7 clr");
    expect_stat(2'b00, "R7 clr clears");
    strobes(16, 0, "R8 set");
    pulse_clr("R8 clr open");
    expect_stat(2'b00, "R8 clr while open");
    strobes(15, 0, "R8 rerun");
    expect_stat(2'b00, "R8 not yet");
    strobes(1, 0, "R8 re-set");
    expect_stat(2'b01, "R8 re-set");
    pulse_clr("R8 final clr");
    latch_mode = 0;

    // R3: long filter
    long_sel = 1;
    strobes(1023, 0, "R3 long");
    expect_stat(2'b00, "R3 1023 misses");
    strobes(1, 0, "R3 1024th");
    expect_stat(2'b01, "R3 1024th sets");
    long_sel = 0;
    strobes(16, 1, "R3 back");

    // Random phase against the reference
    for (int seg = 0; seg < 80; seg++) begin
      int bias = $urandom_range(0, 2);
      latch_mode = ($urandom_range(0, 3) == 0);
      for (int c = 0; c < 40; c++) begin
        en        = ($urandom_range(0, 63) != 0);
        active    = ($urandom_range(0, 63) != 0);
        hs_recirc = ($urandom_range(0, 15) != 0);
        if ($urandom_range(0, 99) == 0) dir = ~dir;
        clr_flt   = ($urandom_range(0, 49) == 0);
        strobe    = ($urandom_range(0, 1) == 1);
        spike     = (bias == 0) ? ($urandom_range(0, 19) == 0) :
                    (bias == 1) ? ($urandom_range(0, 19) != 0) :
                                  $urandom_range(0, 1);
        step("R2/R5/R7/R10 random");
      end
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule